// File: doc/BRIEF.md
# Status-Select Condition Evaluator

This block decides, for the descriptor a DMA channel is currently executing, whether the channel should raise an interrupt, take a branch and hold in a wait. Each decision compares the four device status bits of the channel, driven by the attached device, against a programmable mask and compare value. Each decision has its own select word. The compare result is then qualified by a two-bit mode taken from the descriptor: never, act if the compare matches, act if it does not match, or always.

The sequencer around the block supplies the three select words, the status bits and the three mode fields. It reads back four registered indications. Interrupt request, branch taken and wait hold say whether each action applies. A fourth indication, sequential advance, says that the channel moves on to the next descriptor in memory instead of to the branch target. Every input is captured in a register stage and every output is registered, so a result appears two clock edges after its inputs.

Top module: `stat_cond_eval`

## Requirements
- R1: While reset is high, and on the first cycle after it, irq_raise, branch_take and wait_hold are 0 and seq_advance is 1, whatever the inputs are.
- R2: In each select word, bits 19:16 are the mask and bits 3:0 are the compare value. All other bits of the select word have no effect on any output.
- R3: A condition matches when (dev_status AND mask) equals (value AND mask). With a zero mask it always matches.
- R4: Mode code 0 (never) drives the related output to 0.
- R5: Mode code 3 (always) drives the related output to 1. A wait mode of 3 therefore always holds the channel on its descriptor.
- R6: Mode code 1 (if match) drives the related output to the match result.
- R7: Mode code 2 (if no match) drives the related output to the inverse of the match result.
- R8: The interrupt, branch and wait decisions each use only their own select word and their own mode field.
- R9: seq_advance is the complement of branch_take. A branch mode of 0 always gives seq_advance = 1.
- R10: Outputs reflect the inputs sampled two rising clock edges earlier. After one edge they still show the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_status | input | 4 | Device status bits of the channel |
| intr_sel | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| branch_sel | input | 32 | Branch select word (mask 19:16, value 3:0) |
| wait_sel | input | 32 | Wait select word (mask 19:16, value 3:0) |
| intr_mode | input | 2 | Interrupt mode: 0 never, 1 if match, 2 if no match, 3 always |
| branch_mode | input | 2 | Branch mode, same encoding |
| wait_mode | input | 2 | Wait mode, same encoding |
| irq_raise | output | 1 | Interrupt requested |
| branch_take | output | 1 | Branch to the dependent address |
| seq_advance | output | 1 | Advance to the next sequential descriptor |
| wait_hold | output | 1 | Hold the channel on the current descriptor |

## Verification
A wrong captured mask, value or mode shows up as a flipped decision on exactly one output, two edges after the stimulus, and only for status patterns that the faulty bit affects. For that reason the stimulus sweeps status bits against random masks under every mode. A swap between the three lanes shows up when the modes of the lanes differ, and the bench drives them differently on purpose. A fault in the separate advance logic shows as seq_advance and branch_take agreeing, and this is visible in the same cycle the branch decision appears.

// File: rtl/stat_cond_pkg.sv
package stat_cond_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NEVER    = 2'd0,
    MODE_IF_TRUE  = 2'd1,
    MODE_IF_FALSE = 2'd2,
    MODE_ALWAYS   = 2'd3
  } act_mode_e;

  localparam int LANE_INTR   = 0;
  localparam int LANE_BRANCH = 1;
  localparam int LANE_WAIT   = 2;
  localparam int LANE_COUNT  = 3;

endpackage

// File: rtl/stat_cond_match.sv
module stat_cond_match #(
  parameter int STAT_W   = 4,
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0
) (
  input  logic [STAT_W-1:0] status,
  input  logic [SEL_W-1:0]  sel_word,
  output logic              hit
);

  logic [STAT_W-1:0] mask_f;
  logic [STAT_W-1:0] val_f;

  always_comb begin
    mask_f = sel_word[MASK_LSB +: STAT_W];
    val_f  = sel_word[VAL_LSB +: STAT_W];
    hit    = ((status & mask_f) == (val_f & mask_f));
    if (mask_f == '0) begin
      AST_ZERO_MASK_HIT: assert (hit) else $error("zero mask must match"); // R3
    end
  end

endmodule

// File: rtl/stat_cond_gate.sv
module stat_cond_gate
  import stat_cond_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              hit,
  output logic              act
);

  always_comb begin
    unique case (act_mode_e'(mode))
      MODE_NEVER:    act = 1'b0;
      MODE_IF_TRUE:  act = hit;
      MODE_IF_FALSE: act = ~hit;
      MODE_ALWAYS:   act = 1'b1;
      default:       act = 1'b0;
    endcase
  end

endmodule

// File: rtl/stat_cond_eval.sv
module stat_cond_eval
  import stat_cond_pkg::*;
#(
  parameter int STAT_W   = 4,
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [SEL_W-1:0]  intr_sel,
  input  logic [SEL_W-1:0]  branch_sel,
  input  logic [SEL_W-1:0]  wait_sel,
  input  logic [MODE_W-1:0] intr_mode,
  input  logic [MODE_W-1:0] branch_mode,
  input  logic [MODE_W-1:0] wait_mode,
  output logic              irq_raise,
  output logic              branch_take,
  output logic              seq_advance,
  output logic              wait_hold
);

  localparam int NL = LANE_COUNT;

  logic [NL-1:0][SEL_W-1:0]  sel_in;
  logic [NL-1:0][MODE_W-1:0] mode_in;

  logic [STAT_W-1:0]         stat_q;
  logic [NL-1:0][SEL_W-1:0]  sel_q;
  logic [NL-1:0][MODE_W-1:0] mode_q;

  logic [NL-1:0] hit;
  logic [NL-1:0] act;
  logic [NL-1:0] act_q;
  logic          adv_d;
  logic          adv_q;

  assign sel_in[LANE_INTR]    = intr_sel;
  assign sel_in[LANE_BRANCH]  = branch_sel;
  assign sel_in[LANE_WAIT]    = wait_sel;
  assign mode_in[LANE_INTR]   = intr_mode;
  assign mode_in[LANE_BRANCH] = branch_mode;
  assign mode_in[LANE_WAIT]   = wait_mode;

  // capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      sel_q  <= '0;
      mode_q <= '0;
    end else begin
      stat_q <= dev_status;
      sel_q  <= sel_in;
      mode_q <= mode_in;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    stat_cond_match #(
      .STAT_W  (STAT_W),
      .SEL_W   (SEL_W),
      .MASK_LSB(MASK_LSB),
      .VAL_LSB (VAL_LSB)
    ) u_match (
      .status  (stat_q),
      .sel_word(sel_q[g]),
      .hit     (hit[g])
    );

    stat_cond_gate u_gate (
      .mode(mode_q[g]),
      .hit (hit[g]),
      .act (act[g])
    );

    AST_NEVER_QUIET: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == MODE_NEVER) |=> !act_q[g]) else $error("never mode fired"); // R4
    AST_ALWAYS_FIRES: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == MODE_ALWAYS) |=> act_q[g]) else $error("always mode idle"); // R5
    AST_IFTRUE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == MODE_IF_TRUE) |=> (act_q[g] == $past(hit[g]))) else $error("if-match wrong"); // R6
    AST_IFFALSE_INVERTS: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == MODE_IF_FALSE) |=> (act_q[g] != $past(hit[g]))) else $error("if-no-match wrong"); // R7
  end

  // advance decided from the mode table directly, not by inverting the branch flop
  always_comb begin
    unique case (act_mode_e'(mode_q[LANE_BRANCH]))
      MODE_NEVER:    adv_d = 1'b1;
      MODE_IF_TRUE:  adv_d = ~hit[LANE_BRANCH];
      MODE_IF_FALSE: adv_d = hit[LANE_BRANCH];
      MODE_ALWAYS:   adv_d = 1'b0;
      default:       adv_d = 1'b1;
    endcase
  end

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      adv_q <= 1'b1;
    end else begin
      act_q <= act;
      adv_q <= adv_d;
    end
  end

  assign irq_raise   = act_q[LANE_INTR];
  assign branch_take = act_q[LANE_BRANCH];
  assign wait_hold   = act_q[LANE_WAIT];
  assign seq_advance = adv_q;

  AST_ADVANCE_EXCL: assert property (@(posedge clk) disable iff (rst)
    seq_advance != branch_take) else $error("advance and branch agree"); // R9

endmodule

// File: tb/stat_cond_eval_tb.sv
`timescale 1ns/1ps
module stat_cond_eval_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dev_status = '0;
  logic [31:0] intr_sel = '0, branch_sel = '0, wait_sel = '0;
  logic [1:0]  intr_mode = '0, branch_mode = '0, wait_mode = '0;
  logic        irq_raise, branch_take, seq_advance, wait_hold;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  stat_cond_eval u_dut (
    .clk(clk), .rst(rst), .dev_status(dev_status),
    .intr_sel(intr_sel), .branch_sel(branch_sel), .wait_sel(wait_sel),
    .intr_mode(intr_mode), .branch_mode(branch_mode), .wait_mode(wait_mode),
    .irq_raise(irq_raise), .branch_take(branch_take),
    .seq_advance(seq_advance), .wait_hold(wait_hold)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: got=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit exp_act(input logic [1:0] m, input logic [3:0] st, input logic [31:0] s);
    bit c;
    c = ((st & s[19:16]) == (s[3:0] & s[19:16]));
    case (m)
      2'd0: return 1'b0;
      2'd1: return c;
      2'd2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] st,
                       input logic [31:0] si, input logic [31:0] sb, input logic [31:0] sw,
                       input logic [1:0] mi, input logic [1:0] mb, input logic [1:0] mw);
    @(negedge clk);
    dev_status = st; intr_sel = si; branch_sel = sb; wait_sel = sw;
    intr_mode = mi; branch_mode = mb; wait_mode = mw;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string extra);
    bit ei, eb, ew;
    ei = exp_act(intr_mode, dev_status, intr_sel);
    eb = exp_act(branch_mode, dev_status, branch_sel);
    ew = exp_act(wait_mode, dev_status, wait_sel);
    chk(irq_raise,   ei,  {mode_tag(intr_mode), " intr ", extra});
    chk(branch_take, eb,  {mode_tag(branch_mode), " branch ", extra});
    chk(wait_hold,   ew,  {mode_tag(wait_mode), " wait ", extra});
    chk(seq_advance, !eb, {"R9 advance ", extra});
  endtask

  initial begin
    bit old_i;
    void'($urandom(32'h5EED_0C0D));
    // R1: reset with all modes set to always
    dev_status = 4'hF; intr_mode = 2'd3; branch_mode = 2'd3; wait_mode = 2'd3;
    repeat (3) @(negedge clk);
    chk(irq_raise, 1'b0, "R1 irq in reset");
    chk(branch_take, 1'b0, "R1 branch in reset");
    chk(wait_hold, 1'b0, "R1 wait in reset");
    chk(seq_advance, 1'b1, "R1 advance in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(irq_raise, 1'b0, "R1 irq first cycle");
    chk(seq_advance, 1'b1, "R1 advance first cycle");

    // R4/R5: never and always
    drive(4'h5, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 2'd3);
    check_all("never/always");
    chk(wait_hold, 1'b1, "R5 wait always holds");
    chk(seq_advance, 1'b1, "R9 branch never advances");

    // R3: zero mask matches, value ignored
    drive(4'hA, 32'h0000_0005, 32'h0000_0005, 32'h0000_0005, 2'd1, 2'd2, 2'd1);
    chk(irq_raise, 1'b1, "R3 zero mask match");
    check_all("zero mask");

    // R3: full mask exact compare
    drive(4'h9, 32'h000F_0009, 32'h000F_0008, 32'h000F_0009, 2'd1, 2'd1, 2'd2);
    chk(irq_raise, 1'b1, "R3 full mask equal");
    chk(branch_take, 1'b0, "R3 full mask unequal");
    check_all("full mask");

    // R2: junk in bits outside 19:16 and 3:0 ignored
    drive(4'h3, 32'hFFF0_FFF3, 32'h7F02_A5F2, 32'h0000_0000, 2'd1, 2'd1, 2'd0);
    chk(irq_raise, 1'b1, "R2 junk bits ignored intr");
    chk(branch_take, 1'b1, "R2 junk bits ignored branch");

    // R8: independent lanes, same status, different selects and modes
    drive(4'h4, 32'h0004_0004, 32'h0004_0000, 32'h0001_0001, 2'd1, 2'd1, 2'd2);
    chk(irq_raise, 1'b1, "R8 intr own select");
    chk(branch_take, 1'b0, "R8 branch own select");
    chk(wait_hold, 1'b1, "R8 wait own select");

    // R10: latency two edges
    old_i = irq_raise;
    @(negedge clk);
    intr_sel = 32'h0; intr_mode = (old_i) ? 2'd0 : 2'd3;
    @(negedge clk);
    chk(irq_raise, old_i, "R10 one edge keeps old");
    @(negedge clk);
    chk(irq_raise, !old_i, "R10 two edges new");

    // random sweep
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      drive(4'($urandom), a, b, c, 2'($urandom), 2'($urandom), 2'($urandom));
      check_all("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule